// File: doc/BRIEF.md
# Integer Flag and Condition Field Generator

This block sits after an integer ALU. From the operands, the ALU result and a few per-instruction controls, it works out the status flags the instruction may update. These are a full-width carry, a half-width carry, a full-width overflow, a half-width overflow and the sticky summary-overflow bit. It also builds the four-bit condition field 0 that records the sign of the result. Each output comes with its own write enable, so that the register file logic can merge it into the architectural status registers.

Before any flag is evaluated, operand A can be complemented and operand B can be replaced by an immediate. A separate overflow indication from a divider can override both overflow flags. A two-bit mask lets an instruction that has already written a carry flag keep that flag from being written again. The logic is combinational. A parameter can add one register stage to all outputs, and that stage is reset asynchronously.

Top module: `fx_flag_gen`

## Requirements
- R1: When `inv_a` is 1, every flag is evaluated on the bitwise complement of `op_a` rather than on `op_a`.
- R2: When `imm_valid` is 1, `imm` takes the place of `op_b` for every flag, and `op_b` has no effect on any output.
- R3: `ca` is 1 exactly when either effective operand, read as unsigned, is greater than `result`.
- R4: With HALF = XLEN/2, `ca32` depends on `is_add`. When `is_add` is 1, `ca32` = `result[HALF]` XOR effective A bit HALF XOR effective B bit HALF. Otherwise `ca32` is 1 exactly when the low HALF bits of either effective operand, read as unsigned, are greater than the low HALF bits of `result`.
- R5: `ov` is 1 exactly when the effective operands have equal sign bits (bit XLEN-1) and the sign bit of `result` differs from them. `ov32` applies the same rule with bit HALF-1 as the sign.
- R6: When `div_ov_valid` is 1, both `ov` and `ov32` equal `div_ov`.
- R7: `ov_we` and `so_we` are both 1 exactly when `oe_en` or `div_ov_valid` is 1. `so_out` is `so_in` OR `ov` when `so_we` is 1, and `so_in` otherwise.
- R8: `ca_we` is `carry_en` AND NOT `done_mask[0]`. `ca32_we` is `carry_en` AND NOT `done_mask[1]`.
- R9: `cr0_we` equals `rc_en`. `cr0` is {negative, positive, zero, SO}, with bit 3 holding negative and bit 0 holding SO. The sign tests read `result` as signed, and SO is the updated `so_out`.
- R10: With REG_OUT = 1, every output appears one clock after its inputs, and every output is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| op_a | input | XLEN | Operand A |
| op_b | input | XLEN | Operand B |
| result | input | XLEN | ALU result |
| imm | input | XLEN | Immediate operand |
| is_add | input | 1 | Operation is an add (selects the half-carry rule) |
| inv_a | input | 1 | Complement operand A before evaluation |
| imm_valid | input | 1 | Use the immediate as the second operand |
| carry_en | input | 1 | Instruction updates the carry flags |
| oe_en | input | 1 | Instruction updates the overflow flags |
| rc_en | input | 1 | Instruction records condition field 0 |
| div_ov_valid | input | 1 | A divider overflow indication is present |
| div_ov | input | 1 | Divider overflow value |
| done_mask | input | 2 | Bit 0 blocks the ca write, bit 1 blocks the ca32 write |
| so_in | input | 1 | Current summary-overflow bit |
| ca | output | 1 | Full-width carry |
| ca_we | output | 1 | Write enable for ca |
| ca32 | output | 1 | Half-width carry |
| ca32_we | output | 1 | Write enable for ca32 |
| ov | output | 1 | Full-width overflow |
| ov32 | output | 1 | Half-width overflow |
| ov_we | output | 1 | Write enable for ov and ov32 |
| so_out | output | 1 | New summary-overflow bit |
| so_we | output | 1 | Write enable for so_out |
| cr0 | output | 4 | Condition field 0 |
| cr0_we | output | 1 | Write enable for cr0 |

## Verification
The case that is hardest to reach from the ports is the half-width flag that disagrees with its full-width partner. Examples are a carry out of the low half with no carry out of the top, or an overflow of the low half while the whole word does not overflow. Random wide operands almost never land there. The bench therefore sets XLEN to 8, so that the half boundary falls at bit 4. It then sweeps every pair of operands through an add, which visits every combination of the two carries and the two overflows. Further sweeps cover complemented operands, immediate substitution and unrelated results.

// File: rtl/fx_flag_gen.sv
module fx_flag_gen #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] result,
  input  logic [XLEN-1:0] imm,
  input  logic            is_add,
  input  logic            inv_a,
  input  logic            imm_valid,
  input  logic            carry_en,
  input  logic            oe_en,
  input  logic            rc_en,
  input  logic            div_ov_valid,
  input  logic            div_ov,
  input  logic [1:0]      done_mask,
  input  logic            so_in,
  output logic            ca,
  output logic            ca_we,
  output logic            ca32,
  output logic            ca32_we,
  output logic            ov,
  output logic            ov32,
  output logic            ov_we,
  output logic            so_out,
  output logic            so_we,
  output logic [3:0]      cr0,
  output logic            cr0_we
);
  localparam int HALF = XLEN / 2;
  localparam int NOUT = 14;

  logic [XLEN-1:0] opa, opb;
  assign opa = inv_a ? ~op_a : op_a;
  assign opb = imm_valid ? imm : op_b;

  logic ca_c, ca32_add, ca32_cmp, ca32_c;
  assign ca_c     = (opa > result) | (opb > result);
  assign ca32_add = result[HALF] ^ opa[HALF] ^ opb[HALF];
  assign ca32_cmp = (opa[HALF-1:0] > result[HALF-1:0]) |
                    (opb[HALF-1:0] > result[HALF-1:0]);
  assign ca32_c   = is_add ? ca32_add : ca32_cmp;

  logic ov_full, ov_half, ov_c, ov32_c, ov_we_c, so_c;
  assign ov_full = (opa[XLEN-1] == opb[XLEN-1]) & (result[XLEN-1] != opa[XLEN-1]);
  assign ov_half = (opa[HALF-1] == opb[HALF-1]) & (result[HALF-1] != opa[HALF-1]);
  assign ov_c    = div_ov_valid ? div_ov : ov_full;
  assign ov32_c  = div_ov_valid ? div_ov : ov_half;
  assign ov_we_c = oe_en | div_ov_valid;
  assign so_c    = so_in | (ov_we_c & ov_c);

  logic neg, zero, pos;
  assign neg  = result[XLEN-1];
  assign zero = ~|result;
  assign pos  = ~neg & ~zero;

  logic [NOUT-1:0] nxt, q;
  assign nxt = {ca_c, carry_en & ~done_mask[0],
                ca32_c, carry_en & ~done_mask[1],
                ov_c, ov32_c, ov_we_c, so_c, ov_we_c,
                neg, pos, zero, so_c, rc_en};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_comb
      assign q = nxt;
    end
  endgenerate

  assign {ca, ca_we, ca32, ca32_we, ov, ov32, ov_we, so_out, so_we, cr0, cr0_we} = q;
endmodule

module fx_flag_gen_chk #(
  parameter bit REG_OUT = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] done_mask,
  input logic       ca_we,
  input logic       ca32_we,
  input logic       ov,
  input logic       ov_we,
  input logic       so_out,
  input logic       so_we,
  input logic [3:0] cr0,
  input logic       cr0_we
);
  generate
    if (REG_OUT) begin : g_lat
      assert_mask_ca_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_mask[0]) |-> !ca_we);
      assert_mask_ca32_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_mask[1]) |-> !ca32_we);
    end else begin : g_now
      assert_mask_ca_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_mask[0] |-> !ca_we);
      assert_mask_ca32_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_mask[1] |-> !ca32_we);
    end
  endgenerate

  assert_sticky_so_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (so_we && ov) |-> so_out);
  assert_ov_so_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ov_we |-> so_we);
  assert_cr0_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_we |-> ($countones(cr0[3:1]) == 1));
  assert_cr0_so_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cr0_we && so_we) |-> (cr0[0] == so_out));
endmodule

bind fx_flag_gen fx_flag_gen_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_fx_flag_gen.sv
module sim_fx_flag_gen;
  localparam int W = 8;
  localparam int H = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b, r, im;
  logic is_add, inv_a, imm_v, cen, oe, rc, dv, dvo, so;
  logic [1:0] mask;

  logic ca0, caw0, c320, c32w0, ov0, ov320, ovw0, so0, sow0, crw0;
  logic [3:0] cr_0;
  logic ca1, caw1, c321, c32w1, ov1, ov321, ovw1, so1, sow1, crw1;
  logic [3:0] cr_1;

  fx_flag_gen #(.XLEN(W), .REG_OUT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .result(r), .imm(im),
    .is_add(is_add), .inv_a(inv_a), .imm_valid(imm_v), .carry_en(cen),
    .oe_en(oe), .rc_en(rc), .div_ov_valid(dv), .div_ov(dvo),
    .done_mask(mask), .so_in(so),
    .ca(ca0), .ca_we(caw0), .ca32(c320), .ca32_we(c32w0), .ov(ov0),
    .ov32(ov320), .ov_we(ovw0), .so_out(so0), .so_we(sow0), .cr0(cr_0),
    .cr0_we(crw0));

  fx_flag_gen #(.XLEN(W), .REG_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .result(r), .imm(im),
    .is_add(is_add), .inv_a(inv_a), .imm_valid(imm_v), .carry_en(cen),
    .oe_en(oe), .rc_en(rc), .div_ov_valid(dv), .div_ov(dvo),
    .done_mask(mask), .so_in(so),
    .ca(ca1), .ca_we(caw1), .ca32(c321), .ca32_we(c32w1), .ov(ov1),
    .ov32(ov321), .ov_we(ovw1), .so_out(so1), .so_we(sow1), .cr0(cr_1),
    .cr0_we(crw1));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic logic [13:0] model();
    logic [W-1:0] ae, be;
    int sa, sb, sr, la, lb, lr;
    logic c, c32, o, o32, owe, s;
    ae = inv_a ? ~a : a;
    be = imm_v ? im : b;
    c = (int'(ae) > int'(r)) || (int'(be) > int'(r));
    if (is_add) c32 = r[H] ^ ae[H] ^ be[H];
    else c32 = (int'(ae) % (1 << H) > int'(r) % (1 << H)) ||
               (int'(be) % (1 << H) > int'(r) % (1 << H));
    sa = int'(ae) >= (1 << (W-1)) ? int'(ae) - (1 << W) : int'(ae);
    sb = int'(be) >= (1 << (W-1)) ? int'(be) - (1 << W) : int'(be);
    sr = int'(r)  >= (1 << (W-1)) ? int'(r)  - (1 << W) : int'(r);
    la = int'(ae) % (1 << H); if (la >= (1 << (H-1))) la -= (1 << H);
    lb = int'(be) % (1 << H); if (lb >= (1 << (H-1))) lb -= (1 << H);
    lr = int'(r)  % (1 << H); if (lr >= (1 << (H-1))) lr -= (1 << H);
    o   = ((sa < 0) == (sb < 0)) && ((sr < 0) != (sa < 0));
    o32 = ((la < 0) == (lb < 0)) && ((lr < 0) != (la < 0));
    if (dv) begin o = dvo; o32 = dvo; end
    owe = oe | dv;
    s = owe ? (so | o) : so;
    return {c, cen & ~mask[0], c32, cen & ~mask[1], o, o32, owe, s, owe,
            sr < 0, sr > 0, sr == 0, s, rc};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h r=%h imm=%h actual=%b expected=%b", tag, a, b, r, im, act, exp);
    end
  endtask

  task automatic apply_check(input string tc, input string to, input string tr);
    logic [13:0] e;
    #2;
    e = model();
    chk(tc, {4'b0, ca0, caw0, c320, c32w0}, {4'b0, e[13:10]});
    chk(to, {3'b0, ov0, ov320, ovw0, so0, sow0}, {3'b0, e[9:5]});
    chk(tr, {3'b0, cr_0, crw0}, {3'b0, e[4:0]});
  endtask

  task automatic set_ctl(input logic ad, input logic iv, input logic ib);
    is_add = ad; inv_a = iv; imm_v = ib;
    cen = 1; oe = 1; rc = 1; dv = 0; dvo = 0; mask = 2'b00; so = 0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    a = 0; b = 0; r = 0; im = 0;
    set_ctl(1, 0, 0);
    #25;
    // R10: registered outputs held at zero in reset
    chk("R10 reset", {ca1, caw1, c321, c32w1, ov1, ov321, ovw1, so1},
        8'h00);
    chk("R10 reset", {3'b0, sow1, cr_1}, 8'h00);
    checks++; if (crw1 !== 1'b0) begin errors++; $display("FAIL R10 reset cr0_we actual=%b expected=0", crw1); end
    @(posedge clk); #1 rst_n = 1;
    @(posedge clk); #1;

    // R3 R4 R5 R7 R9: exhaustive add sweep
    set_ctl(1, 0, 0);
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        a = W'(i); b = W'(j); r = W'(i + j); so = a[0];
        apply_check("R3/R4 add", "R5/R7 add", "R9 add");
      end
    end

    // R1: complemented A, subtract-from result
    set_ctl(0, 1, 0);
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j += 7) begin
        a = W'(i); b = W'(j); r = W'((~i) + j + 1);
        apply_check("R1 carry", "R1 ov", "R1 cr0");
      end
    end

    // R2: immediate replaces B; B is garbage
    set_ctl(1, 0, 1);
    for (int i = 0; i < 256; i += 3) begin
      for (int j = 0; j < 256; j += 5) begin
        a = W'(i); im = W'(j); b = W'($urandom); r = W'(i + j);
        apply_check("R2 carry", "R2 ov", "R2 cr0");
      end
    end

    // R4: non-add rule against unrelated results
    set_ctl(0, 0, 0);
    for (int k = 0; k < 6000; k++) begin
      a = W'($urandom); b = W'($urandom); r = W'($urandom);
      apply_check("R4 cmp", "R5 cmp", "R9 cmp");
    end

    // R6 R7 R8: control combinations
    for (int m = 0; m < 256; m++) begin
      set_ctl(m[0], 0, 0);
      mask = m[2:1]; cen = m[3]; oe = m[4]; dv = m[5]; dvo = m[6]; so = m[7];
      rc = m[3] ^ m[4];
      for (int k = 0; k < 8; k++) begin
        a = W'($urandom); b = W'($urandom); r = W'(a + b);
        apply_check("R8 enables", "R6/R7 div", "R9 so");
      end
    end

    // R9: sign edge results
    set_ctl(0, 0, 0);
    oe = 0;
    for (int k = 0; k < 4; k++) begin
      so = k[0];
      a = 0; b = 0;
      r = W'(0);               apply_check("R9 zero", "R7 keep", "R9 zero");
      r = W'(1 << (W-1));      apply_check("R9 neg",  "R7 keep", "R9 neg");
      r = W'((1 << (W-1)) - 1); apply_check("R9 pos", "R7 keep", "R9 pos");
    end

    // R10: one-cycle latency of the registered variant
    for (int k = 0; k < 40; k++) begin
      logic [13:0] e;
      @(posedge clk); #3;
      set_ctl(k[0], k[1], 0);
      so = k[2]; dv = k[3]; dvo = k[4];
      a = W'($urandom); b = W'($urandom); r = W'(a + b);
      e = model();
      @(posedge clk); #3;
      chk("R10 latency", {ca1, caw1, c321, c32w1, ov1, ov321, ovw1, so1}, e[13:6]);
      chk("R10 latency", {3'b0, sow1, cr_1}, {3'b0, e[5:1]});
    end

    finish_up();
  end
endmodule